// File: doc/BRIEF.md
# Serial Port Sample-Rate Generator

This block produces the bit clock and the periodic frame pulse for a synchronous serial port. It runs entirely on the system clock. The bit clock is a registered level, and its edges are derived from a chosen source. That source is either the system clock itself, where every cycle is a source tick, or an external clock input. The external input is resynchronised and its rising or falling edges, as selected, count as source ticks. A programmable divider turns source ticks into bit-clock half periods. A frame counter then counts bit-clock rising edges to build a frame pulse of programmable width and period.

The divider and the frame logic have separate active-high enables, and clearing either one holds that part in its cleared state. An optional alignment mode restarts both the divider and the frame counter on every rising edge of the external receive frame-sync input. A select pin picks where the transmit frame sync comes from. It is either the generated frame pulse or a strobe that marks each hand-over of a word into the transmit shift register. The configuration fields are plain static inputs, so the block has no streaming interface and needs no flow control.

Top module: `srg_top`

## Requirements
- R1: While `rst_n` is low, `bclk_out`, `fs_out` and `tx_fs_out` are 0 (with `xfer_strobe` low).
- R2: With `src_sys`=1 and `clk_gen_en`=1, `bclk_out` toggles every `div_ratio`+1 system clock cycles, so it is high for `div_ratio`+1 cycles and low for `div_ratio`+1 cycles; a ratio of 0 toggles it on every cycle.
- R3: While `clk_gen_en` is 0, `bclk_out` stays 0 and the divider is cleared. When the enable is set with `src_sys`=1, `bclk_out` first goes high `div_ratio`+1 cycles later.
- R4: With `src_sys`=0 and `ext_fall`=0, only rising edges of `ext_clk_in` are source ticks. `bclk_out` changes on the third system clock edge after the input edge is presented.
- R5: With `src_sys`=0 and `ext_fall`=1, only falling edges of `ext_clk_in` are source ticks, with the same three-edge latency.
- R6: `fs_out` rises one cycle after a `bclk_out` rising edge that opens a frame. It stays high for `fs_width`+1 bit-clock periods, where one bit-clock period is 2×(`div_ratio`+1) cycles with the internal source.
- R7: Frames repeat every `fs_period`+1 bit-clock periods.
- R8: While `frame_en` is 0, `fs_out` is 0. After it is set, the first frame opens at the next `bclk_out` rising edge.
- R9: When `fs_width` >= `fs_period`, `fs_out` stays high once the first frame has opened.
- R10: With `align_en`=1, a rising edge on `rx_fs_in` restarts the generator. Three cycles after the edge is presented, `bclk_out` and `fs_out` are 0. `bclk_out` then rises `div_ratio`+1 cycles later with the internal source, and a new frame opens there.
- R11: With `align_en`=0, `rx_fs_in` has no effect on the frame timing.
- R12: `tx_fs_out` follows `fs_out` when `tx_fs_gen`=1, and follows `xfer_strobe` in the same cycle when `tx_fs_gen`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_gen_en | input | 1 | Divider enable; 0 holds the bit clock cleared |
| frame_en | input | 1 | Frame logic enable; 0 holds the frame pulse cleared |
| src_sys | input | 1 | Source select: 1 system clock, 0 external clock |
| ext_fall | input | 1 | External edge select: 0 rising, 1 falling |
| align_en | input | 1 | Restart on receive frame-sync rising edges |
| tx_fs_gen | input | 1 | Transmit frame sync: 1 from the frame pulse, 0 from `xfer_strobe` |
| div_ratio | input | 8 | Divider ratio minus one |
| fs_width | input | 8 | Frame pulse width minus one, in bit-clock periods |
| fs_period | input | 12 | Frame period minus one, in bit-clock periods |
| ext_clk_in | input | 1 | External clock source, asynchronous |
| rx_fs_in | input | 1 | Receive frame sync, asynchronous |
| xfer_strobe | input | 1 | One-cycle mark of a word hand-over to the shift register |
| bclk_out | output | 1 | Generated bit clock level |
| fs_out | output | 1 | Generated frame pulse |
| tx_fs_out | output | 1 | Selected transmit frame sync |

## Verification
Each result has a fixed lag, and every check samples exactly there. With the internal source, a bit-clock edge lands `div_ratio`+1 cycles after the previous one. The frame pulse trails the bit-clock rising edge that opens a frame by one cycle. External clock edges and receive frame-sync edges act after two synchroniser flops and an edge register, so their effect shows three cycles after the bench presents them. The bench drives inputs at the falling clock edge and samples there. It counts cycles between observed transitions and compares the counts with values computed from the configuration. For the external source, the bench checks the phase of every bit-clock change against the edge of the generated external clock that it selected.

// File: rtl/srg_pkg.sv
package srg_pkg;
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_SYS = 1'b1
  } srg_src_e;

  // Number of flops on each asynchronous input before edge detection.
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/srg_sync.sv
module srg_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rose,
  output logic fell
);
  logic [DEPTH-1:0] chain;
  logic             last;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[DEPTH-2:0], async_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[DEPTH-1];
  end

  assign level = chain[DEPTH-1];
  assign rose  = level & ~last;
  assign fell  = ~level & last;
endmodule

// File: rtl/srg_tick_src.sv
module srg_tick_src
  import srg_pkg::*;
#(
  parameter int unsigned DEPTH = SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_sys,
  input  logic ext_fall,
  input  logic align_en,
  input  logic ext_clk_in,
  input  logic rx_fs_in,
  output logic tick,
  output logic restart
);
  logic ext_lvl, ext_rose, ext_fell;
  logic rx_lvl, rx_rose, rx_fell;
  logic ext_tick;

  srg_sync #(.DEPTH(DEPTH)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ext_clk_in),
    .level(ext_lvl), .rose(ext_rose), .fell(ext_fell)
  );

  srg_sync #(.DEPTH(DEPTH)) u_rx_sync (
    .clk(clk), .rst_n(rst_n), .async_in(rx_fs_in),
    .level(rx_lvl), .rose(rx_rose), .fell(rx_fell)
  );

  assign ext_tick = ext_fall ? ext_fell : ext_rose;
  assign tick     = (srg_src_e'(src_sys) == SRC_SYS) ? 1'b1 : ext_tick;
  assign restart  = align_en & rx_rose;

  // R4 / R5: an external tick always coincides with a change of the synchronised level.
  assert_ext_tick_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_sys && tick) |-> (ext_lvl != $past(ext_lvl)));

  // R11: no restart is ever raised with alignment off.
  assert_no_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> (align_en && rx_lvl && !$past(rx_lvl)));
endmodule

// File: rtl/srg_clk_div.sv
module srg_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tick,
  input  logic             restart,
  input  logic [DIV_W-1:0] div_ratio,
  output logic             bclk,
  output logic             rise_p
);
  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap = (cnt >= div_ratio);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      bclk   <= 1'b0;
      rise_p <= 1'b0;
    end else if (!en || restart) begin
      cnt    <= '0;
      bclk   <= 1'b0;
      rise_p <= 1'b0;
    end else begin
      rise_p <= 1'b0;
      if (tick) begin
        if (wrap) begin
          cnt    <= '0;
          bclk   <= ~bclk;
          rise_p <= ~bclk;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3: a disabled divider is cleared in the next cycle.
  assert_hold_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bclk && cnt == '0));

  // R10: a restart leaves the bit clock low with no pending rise.
  assert_restart_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!bclk && !rise_p));

  // R2: the bit clock moves only on a source tick, a restart or a disable.
  assert_toggle_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bclk) |-> $past(tick || restart || !en));

  // R2: the rise marker is only seen while the bit clock is high.
  assert_rise_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rise_p |-> bclk);
endmodule

// File: rtl/srg_frame.sv
module srg_frame #(
  parameter int unsigned WID_W = 8,
  parameter int unsigned PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             restart,
  input  logic             rise_p,
  input  logic [WID_W-1:0] fs_width,
  input  logic [PER_W-1:0] fs_period,
  output logic             fs
);
  localparam int unsigned CMP_W = (WID_W > PER_W) ? WID_W : PER_W;

  logic [PER_W-1:0] fcnt;
  logic [PER_W-1:0] nxt;
  logic             started;

  always_comb begin
    if (!started || fcnt >= fs_period) nxt = '0;
    else                               nxt = fcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcnt    <= '0;
      started <= 1'b0;
      fs      <= 1'b0;
    end else if (!en || restart) begin
      fcnt    <= '0;
      started <= 1'b0;
      fs      <= 1'b0;
    end else if (rise_p) begin
      fcnt    <= nxt;
      started <= 1'b1;
      fs      <= (CMP_W'(nxt) <= CMP_W'(fs_width));
    end
  end

  // R8: a disabled frame logic drives no pulse.
  assert_fs_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !fs);

  // R6: the pulse opens only right after a bit-clock rising edge.
  assert_fs_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fs) |-> $past(rise_p));

  // R7: the frame position changes only on a bit-clock rising edge or a clear.
  assert_fcnt_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fcnt) |-> $past(rise_p || !en || restart));
endmodule

// File: rtl/srg_top.sv
module srg_top
  import srg_pkg::*;
#(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned WID_W = 8,
  parameter int unsigned PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_gen_en,
  input  logic             frame_en,
  input  logic             src_sys,
  input  logic             ext_fall,
  input  logic             align_en,
  input  logic             tx_fs_gen,
  input  logic [DIV_W-1:0] div_ratio,
  input  logic [WID_W-1:0] fs_width,
  input  logic [PER_W-1:0] fs_period,
  input  logic             ext_clk_in,
  input  logic             rx_fs_in,
  input  logic             xfer_strobe,
  output logic             bclk_out,
  output logic             fs_out,
  output logic             tx_fs_out
);
  logic tick, restart, rise_p;

  srg_tick_src #(.DEPTH(SYNC_DEPTH)) u_src (
    .clk(clk), .rst_n(rst_n), .src_sys(src_sys), .ext_fall(ext_fall),
    .align_en(align_en), .ext_clk_in(ext_clk_in), .rx_fs_in(rx_fs_in),
    .tick(tick), .restart(restart)
  );

  srg_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en(clk_gen_en), .tick(tick),
    .restart(restart), .div_ratio(div_ratio),
    .bclk(bclk_out), .rise_p(rise_p)
  );

  srg_frame #(.WID_W(WID_W), .PER_W(PER_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .en(frame_en), .restart(restart),
    .rise_p(rise_p), .fs_width(fs_width), .fs_period(fs_period),
    .fs(fs_out)
  );

  assign tx_fs_out = tx_fs_gen ? fs_out : xfer_strobe;
endmodule

// File: tb/sim_srg_top.sv
module sim_srg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk_gen_en = 0, frame_en = 0, src_sys = 1, ext_fall = 0;
  logic        align_en = 0, tx_fs_gen = 1;
  logic [7:0]  div_ratio = 0, fs_width = 0;
  logic [11:0] fs_period = 0;
  logic        ext_clk_in = 0, rx_fs_in = 0, xfer_strobe = 0;
  logic        bclk_out, fs_out, tx_fs_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit ext_run = 0;
  bit done = 0;

  always #4 clk = ~clk;

  srg_top u0 (
    .clk(clk), .rst_n(rst_n), .clk_gen_en(clk_gen_en), .frame_en(frame_en),
    .src_sys(src_sys), .ext_fall(ext_fall), .align_en(align_en),
    .tx_fs_gen(tx_fs_gen), .div_ratio(div_ratio), .fs_width(fs_width),
    .fs_period(fs_period), .ext_clk_in(ext_clk_in), .rx_fs_in(rx_fs_in),
    .xfer_strobe(xfer_strobe), .bclk_out(bclk_out), .fs_out(fs_out),
    .tx_fs_out(tx_fs_out)
  );

  function automatic int bit_period(int d);
    return 2 * (d + 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (ext_run) ext_clk_in = ((cyc % 8) < 3);
  endtask

  task automatic wait_sig(bit use_fs, bit v, output int at);
    at = -1;
    for (int i = 0; i < 6000; i++) begin
      step();
      if ((use_fs ? fs_out : bclk_out) == v) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic setup(bit sys, bit fall, int d, int w, int p);
    clk_gen_en = 0; frame_en = 0;
    step();
    src_sys = sys; ext_fall = fall;
    div_ratio = 8'(d); fs_width = 8'(w); fs_period = 12'(p);
    step();
    clk_gen_en = 1; frame_en = 1;
  endtask

  initial begin
    int t0, a, b, c, n, bad, d, w, p, br, fr, r0, r1;
    bit pb;
    void'($urandom(32'd20240611));
    repeat (3) step();
    chk("R1 bclk in reset", bclk_out, 0);
    chk("R1 fs in reset", fs_out, 0);
    chk("R1 tx_fs in reset", tx_fs_out, 0);
    rst_n = 1;
    step();

    // R3: disabled divider holds low, then first rise after div+1 cycles
    div_ratio = 4; src_sys = 1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin step(); if (bclk_out) bad++; end
    chk("R3 bclk held while disabled", bad, 0);
    clk_gen_en = 1; t0 = cyc;
    wait_sig(0, 1, a);
    chk("R3 first rise latency", a - t0, 5);

    // R2: high and low times for several ratios, including 0
    for (int k = 0; k < 5; k++) begin
      d = (k == 0) ? 0 : int'($urandom % 7);
      setup(1, 0, d, 0, 3);
      wait_sig(0, 1, a); wait_sig(0, 0, a);
      wait_sig(0, 1, b); wait_sig(0, 0, c);
      chk("R2 low time", b - a, d + 1);
      chk("R2 high time", c - b, d + 1);
    end

    // R6 / R7: frame width and period, random configurations
    for (int k = 0; k < 6; k++) begin
      d = int'($urandom % 4);
      p = 2 + int'($urandom % 14);
      w = int'($urandom % p);
      if (k == 0) begin d = 0; w = 0; p = 1; end
      setup(1, 0, d, w, p);
      wait_sig(1, 1, a); wait_sig(1, 0, b); wait_sig(1, 1, c);
      chk("R6 pulse width", b - a, (w + 1) * bit_period(d));
      chk("R7 frame period", c - a, (p + 1) * bit_period(d));
    end

    // R9: width not below period keeps the pulse high
    setup(1, 0, 1, 5, 3);
    wait_sig(1, 1, a);
    bad = 0;
    for (int i = 0; i < 100; i++) begin step(); if (!fs_out) bad++; end
    chk("R9 pulse stays high", bad, 0);

    // R8: frame logic disabled, then opens on next bit-clock rise
    setup(1, 0, 2, 1, 5);
    frame_en = 0;
    bad = 0;
    for (int i = 0; i < 60; i++) begin step(); if (fs_out) bad++; end
    chk("R8 pulse held off", bad, 0);
    frame_en = 1; pb = bclk_out; br = -100; fr = -1;
    for (int i = 0; i < 200; i++) begin
      step();
      if (bclk_out && !pb) br = cyc;
      pb = bclk_out;
      if (fs_out) begin fr = cyc; break; end
    end
    chk("R8 frame opens after bit-clock rise", fr - br, 1);
    chk("R6 pulse one cycle after rise", fr - br, 1);

    // R4 / R5: external source, rising and falling edge selection
    for (int k = 0; k < 4; k++) begin
      ext_run = 1;
      setup(0, k[0], k >> 1, 1, 3);
      repeat (20) step();
      n = 0; bad = 0; pb = bclk_out;
      for (int i = 0; i < 96; i++) begin
        step();
        if (bclk_out != pb) begin
          n++;
          if ((cyc % 8) != (k[0] ? 6 : 3)) bad++;
        end
        pb = bclk_out;
      end
      if (k[0]) begin
        chk("R5 falling-edge phase", bad, 0);
        chk("R5 toggles counted", n, (k >> 1) ? 6 : 12);
      end else begin
        chk("R4 rising-edge phase", bad, 0);
        chk("R4 toggles counted", n, (k >> 1) ? 6 : 12);
      end
    end
    ext_run = 0; ext_clk_in = 0;

    // R10: alignment restarts divider and frame
    for (int k = 0; k < 2; k++) begin
      setup(1, 0, 3, 1, 9);
      align_en = 1;
      repeat (30 + int'($urandom % 20)) step();
      rx_fs_in = 1; c = cyc; a = -1; b = -1;
      for (int i = 0; i < 30; i++) begin
        step();
        if (cyc == c + 4) rx_fs_in = 0;
        if (cyc == c + 3) begin
          chk("R10 bclk low after restart", bclk_out, 0);
          chk("R10 fs low after restart", fs_out, 0);
        end
        if (cyc > c + 3 && bclk_out && a < 0) a = cyc;
        if (cyc > c + 3 && fs_out && b < 0) b = cyc;
      end
      chk("R10 bclk rise after restart", a - c, 3 + 4);
      chk("R10 frame opens after restart", b - c, 3 + 5);
      align_en = 0;
    end

    // R11: receive frame sync ignored without alignment
    setup(1, 0, 3, 1, 9);
    wait_sig(1, 1, r0);
    repeat (13) step();
    rx_fs_in = 1; repeat (4) step(); rx_fs_in = 0;
    wait_sig(1, 0, a); wait_sig(1, 1, r1);
    chk("R11 frame phase kept", (r1 - r0) % (10 * bit_period(3)), 0);

    // R12: transmit frame sync source
    tx_fs_gen = 0;
    wait_sig(1, 1, a);
    chk("R12 strobe path ignores pulse", tx_fs_out, 0);
    xfer_strobe = 1; #1;
    chk("R12 strobe passes", tx_fs_out, 1);
    step(); xfer_strobe = 0; #1;
    chk("R12 strobe released", tx_fs_out, 0);
    tx_fs_gen = 1; bad = 0;
    for (int i = 0; i < 100; i++) begin step(); if (tx_fs_out != fs_out) bad++; end
    chk("R12 pulse path follows fs", bad, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule